// File: doc/BRIEF.md
# Sampled PI Current Regulator with Triangle PWM

This block closes a digital current loop around one inverter leg. A sample handshake delivers a signed reference current and a signed measured current. On acceptance the block forms their difference and then advances an incremental (velocity-form) proportional-integral law with fixed coefficients. The new control value is clamped to plus or minus one full scale, and the stored value is the clamped one, so the integrator cannot wind up. A saturation flag reports when the last update hit a rail.

The clamped control value sets the modulation level of a symmetric up/down triangle carrier. The level is taken only at the carrier valley, so the switching edges stay centred. The carrier comparison gives a two-level switching state, and that state drives complementary high-side and low-side gates with a fixed dead band in which both are off. Both gates stay off from reset until the first sample is accepted. For a three-phase converter, place three copies of the block.

Samples use a valid/ready handshake. A sample transfers on a rising clock edge where both `smp_valid` and `smp_ready` are high. The block drops `smp_ready` for exactly one cycle after each transfer while it computes. It raises `smp_ready` again in the next cycle and applies no other back-pressure. A source that keeps `smp_valid` high while `smp_ready` is low must hold its data, and that data transfers in the following cycle.

Top module: `pi_pwm_leg`

## Requirements
- R1: After reset both gates are off, `sat_flag` is low and `smp_ready` is high. Both gates stay off until the first sample has been accepted.
- R2: A sample is accepted on an edge with `smp_valid` and `smp_ready` both high. `smp_ready` is low in the cycle after acceptance and high again in the cycle after that. A sample presented while `smp_ready` is low is not taken at that edge.
- R3: The error is e = ref − meas, held as a 17-bit signed value. In the cycle after acceptance the control value becomes uc + floor((999·e(n) − 967·e(n−1)) / 32768). Here e(n−1) is the previously accepted error, and both uc and e(n−1) start at 0 after reset.
- R4: The control value is limited to the range −32768 to +32768, which is ±1.0. `sat_flag` is high exactly when the most recent update had to be limited.
- R5: The clamped value is the one stored for the next update. As a result, a reversed error pulls the control value off the rail at the very next update.
- R6: The carrier starts at 0 after reset and counts up by one per clock to 999. It holds 999 for one extra cycle, counts down to 0, and holds 0 for one extra cycle. One carrier period is 2000 clocks.
- R7: The modulation level is floor((uc + 32768) · 1000 / 65536). It is loaded only on the edge where the carrier sits at 0 in its down phase, and its reset value is 500.
- R8: The switching state is +1 while carrier < level and −1 otherwise. At level 1000 the state is +1 throughout the period, and at level 0 it is −1 throughout.
- R9: The high-side gate can be on only in state +1 and the low-side gate only in state −1. The two gates are never on together.
- R10: Each change of switching state turns both gates off for exactly 20 clock cycles before the new gate turns on. A further change during that gap starts the gap again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample can be taken this cycle |
| i_ref | input | 16 | Reference current, signed Q1.15 |
| i_meas | input | 16 | Measured current, signed Q1.15 |
| sat_flag | output | 1 | Last control update was clamped |
| gate_hi | output | 1 | High-side switch on |
| gate_lo | output | 1 | Low-side switch on |

## Verification
The loop is driven by six input patterns:
- A zero error gives the 50% duty with a 20-cycle gap, which separates the level mapping and the dead band from the control law.
- A small constant step checks the integral slope: the first update of 304 followed by increments of 9 must give a duty that can only come from the exact floor rescaling.
- Long runs at plus and minus full error check the clamp, the flag and the gate held steadily on.
- A reversed error right after saturation separates a clamped integrator from one that has wound up.
- Back-to-back samples test the ready rule.
- A pseudo-random mix checks the control update against an independent per-cycle model.

// File: rtl/pi_pwm_pkg.sv
package pi_pwm_pkg;

  typedef enum logic {
    CAR_UP   = 1'b0,
    CAR_DOWN = 1'b1
  } car_dir_e;

  // one full-scale unit of a signed word iw bits wide
  function automatic int full_scale(input int iw);
    return 1 << (iw - 1);
  endfunction

endpackage

// File: rtl/pi_incr_law.sv
module pi_incr_law
  import pi_pwm_pkg::*;
#(
  parameter int IW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  parameter int KA   = 999,
  parameter int KB   = 967
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic signed [IW-1:0] ref_i,
  input  logic signed [IW-1:0] meas_i,
  output logic                 busy,
  output logic signed [IW:0]   uc,
  output logic                 sat
);

  localparam int EW = IW + 1;
  localparam int AW = EW + CW + 3;
  localparam int FS = full_scale(IW);
  localparam logic signed [AW-1:0] RAIL_HI = AW'(FS);
  localparam logic signed [AW-1:0] RAIL_LO = -RAIL_HI;
  localparam logic signed [CW-1:0] KA_C = CW'(KA);
  localparam logic signed [CW-1:0] KB_C = CW'(KB);

  logic signed [EW-1:0] e_cur, e_prev;
  logic signed [AW-1:0] prod_a, prod_b, acc, raw;
  logic signed [EW-1:0] uc_nxt;
  logic                 clip;

  // full-precision sum of both products, rescaled once (floor)
  always_comb begin
    prod_a = AW'(e_cur) * AW'(KA_C);
    prod_b = AW'(e_prev) * AW'(KB_C);
    acc    = (AW'(uc) <<< FRAC) + prod_a - prod_b;
    raw    = acc >>> FRAC;
    if (raw > RAIL_HI) begin
      uc_nxt = EW'(RAIL_HI);
      clip   = 1'b1;
    end else if (raw < RAIL_LO) begin
      uc_nxt = EW'(RAIL_LO);
      clip   = 1'b1;
    end else begin
      uc_nxt = EW'(raw);
      clip   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      e_cur  <= '0;
      e_prev <= '0;
      uc     <= '0;
      sat    <= 1'b0;
    end else if (take) begin
      e_cur <= EW'(ref_i) - EW'(meas_i);
      busy  <= 1'b1;
    end else if (busy) begin
      uc     <= uc_nxt;   // clamped value kept: no windup
      sat    <= clip;
      e_prev <= e_cur;
      busy   <= 1'b0;
    end
  end

  p_uc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uc <= EW'(FS)) && (uc >= -EW'(FS)));
  p_sat_rail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> ((uc == EW'(FS)) || (uc == -EW'(FS))));
  p_uc_moves_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(uc) |-> $past(busy));
  p_busy_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

endmodule

// File: rtl/pi_tri_carrier.sv
module pi_tri_carrier
  import pi_pwm_pkg::*;
#(
  parameter int IW   = 16,
  parameter int CMAX = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic signed [IW:0] uc,
  output logic               sw_pos
);

  localparam int CNTW = $clog2(CMAX + 1);
  localparam int PW   = IW + 1 + CNTW + 1;
  localparam int FS   = full_scale(IW);

  car_dir_e        dir;
  logic [CNTW-1:0] cnt, lvl, lvl_nxt;
  logic [IW:0]     off;
  logic [PW-1:0]   prod;
  logic            valley;

  // map -FS..+FS onto 0..CMAX
  always_comb begin
    off     = unsigned'(uc) + (IW+1)'(FS);
    prod    = PW'(off) * PW'(CMAX);
    lvl_nxt = CNTW'(prod >> IW);
  end

  assign valley = (dir == CAR_DOWN) && (cnt == '0);
  assign sw_pos = (cnt < lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= CAR_UP;
      lvl <= CNTW'(CMAX / 2);
    end else begin
      if (valley) lvl <= lvl_nxt;
      if (dir == CAR_UP) begin
        if (cnt == CNTW'(CMAX - 1)) dir <= CAR_DOWN;
        else                        cnt <= cnt + 1'b1;
      end else begin
        if (cnt == '0) dir <= CAR_UP;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || ($past(cnt) == cnt + 1'b1));
  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(CMAX - 1));
  p_lvl_at_valley_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> $past(valley));
  p_full_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == CNTW'(CMAX)) |-> sw_pos);

endmodule

// File: rtl/pi_dead_band.sv
module pi_dead_band #(
  parameter int DEAD = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sw_pos,
  output logic gate_hi,
  output logic gate_lo
);

  localparam int DW = $clog2(DEAD + 1);

  logic          applied;
  logic [DW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied <= 1'b0;
      gap     <= DW'(DEAD);
    end else if (sw_pos != applied) begin
      applied <= sw_pos;
      gap     <= DW'(DEAD);
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
    end
  end

  assign gate_hi = run && (gap == '0) && applied;
  assign gate_lo = run && (gap == '0) && !applied;

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  p_hi_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> !$past(gate_lo));
  p_lo_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> !$past(gate_hi));
  p_hi_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_hi) |=> !gate_lo);

endmodule

// File: rtl/pi_pwm_leg.sv
module pi_pwm_leg #(
  parameter int IW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  parameter int KA   = 999,
  parameter int KB   = 967,
  parameter int CMAX = 1000,
  parameter int DEAD = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [IW-1:0] i_ref,
  input  logic [IW-1:0] i_meas,
  output logic          sat_flag,
  output logic          gate_hi,
  output logic          gate_lo
);

  logic               busy, run, take, sw_pos;
  logic signed [IW:0] uc;

  assign smp_ready = !busy;
  assign take      = smp_valid && smp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= 1'b0;
    else if (take) run <= 1'b1;
  end

  pi_incr_law #(.IW(IW), .CW(CW), .FRAC(FRAC), .KA(KA), .KB(KB)) u_law (
    .clk(clk), .rst_n(rst_n), .take(take),
    .ref_i(signed'(i_ref)), .meas_i(signed'(i_meas)),
    .busy(busy), .uc(uc), .sat(sat_flag)
  );

  pi_tri_carrier #(.IW(IW), .CMAX(CMAX)) u_car (
    .clk(clk), .rst_n(rst_n), .uc(uc), .sw_pos(sw_pos)
  );

  pi_dead_band #(.DEAD(DEAD)) u_db (
    .clk(clk), .rst_n(rst_n), .run(run), .sw_pos(sw_pos),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
  p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_ready |=> smp_ready);
  p_idle_gates_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!gate_hi && !gate_lo && !sat_flag));

endmodule

// File: tb/sim_pi_pwm_leg.sv
module sim_pi_pwm_leg;

  localparam int FS = 32768;
  localparam int CMAX = 1000;
  localparam int DEAD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0;
  logic [15:0] t_ref = '0, t_meas = '0;
  wire rdy, sat, hi, lo;

  pi_pwm_leg u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(v), .smp_ready(rdy),
    .i_ref(t_ref), .i_meas(t_meas), .sat_flag(sat),
    .gate_hi(hi), .gate_lo(lo)
  );

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  bit checking = 0;

  // behavioural reference state
  int m_busy, m_e, m_ep, m_uc, m_sat, m_run, m_cnt, m_up, m_lvl, m_ap, m_dt, m_acc;
  int n_acc, n_s, n_valley, n_olduc, nu;
  longint t;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_e = 0; m_ep = 0; m_uc = 0; m_sat = 0; m_run = 0;
      m_cnt = 0; m_up = 1; m_lvl = CMAX / 2; m_ap = 0; m_dt = DEAD; m_acc = 0;
    end else begin
      n_acc    = (v && !m_busy) ? 1 : 0;
      n_s      = (m_cnt < m_lvl) ? 1 : 0;
      n_valley = (!m_up && m_cnt == 0) ? 1 : 0;
      n_olduc  = m_uc;
      if (m_busy) begin
        t = 64'sd999 * m_e - 64'sd967 * m_ep;
        nu = m_uc + int'(t >>> 15);
        m_sat = (nu > FS || nu < -FS) ? 1 : 0;
        if (nu > FS) nu = FS;
        if (nu < -FS) nu = -FS;
        m_uc = nu;
        m_ep = m_e;
        m_busy = 0;
      end
      if (n_acc != 0) begin
        m_e = int'($signed(t_ref)) - int'($signed(t_meas));
        m_busy = 1;
        m_run = 1;
      end
      if (n_valley != 0) m_lvl = (n_olduc + FS) * CMAX / 65536;
      if (m_up != 0) begin
        if (m_cnt == CMAX - 1) m_up = 0; else m_cnt++;
      end else begin
        if (m_cnt == 0) m_up = 1; else m_cnt--;
      end
      if (n_s != m_ap) begin
        m_ap = n_s; m_dt = DEAD;
      end else if (m_dt > 0) m_dt--;
      m_acc = n_acc;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk("R2 ready", int'(rdy), (m_busy == 0) ? 1 : 0);
      chk("R4 sat_flag", int'(sat), m_sat);
      chk("R3 R5 R6 R7 R8 R10 gate_hi", int'(hi), (m_run != 0 && m_dt == 0 && m_ap != 0) ? 1 : 0);
      chk("R8 R9 R10 gate_lo", int'(lo), (m_run != 0 && m_dt == 0 && m_ap == 0) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic send(input int a, input int b);
    t_ref = 16'(a); t_meas = 16'(b); v = 1'b1;
    do @(negedge clk); while (m_acc == 0);
    v = 1'b0;
    chk("R2 ready low after take", int'(rdy), 0);
  endtask

  task automatic send_gap(input int a, input int b, input int gap);
    @(negedge clk);
    send(a, b);
    repeat (gap) @(negedge clk);
  endtask

  task automatic count_on(input bit pick_hi, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (pick_hi ? hi : lo) c++;
    end
  endtask

  task automatic dead_gap(output int g);
    g = 0;
    while (!hi) @(negedge clk);
    while (hi) @(negedge clk);
    while (!lo) begin g++; @(negedge clk); end
  endtask

  int c, g;
  logic [31:0] seed = 32'h1234_5678;

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset gate_hi", int'(hi), 0);
    chk("R1 reset gate_lo", int'(lo), 0);
    chk("R1 reset ready", int'(rdy), 1);
    chk("R1 reset sat", int'(sat), 0);
    rst_n = 1'b1;
    checking = 1;
    repeat (50) @(negedge clk);
    chk("R1 gates idle before first sample", int'(hi | lo), 0);

    // zero error: 50% duty less the dead band
    repeat (4) send_gap(1234, 1234, 10);
    repeat (2100) @(negedge clk);
    count_on(1, 2000, c);
    chk("R8 duty at zero error", c, 2 * 500 - DEAD);
    dead_gap(g);
    chk("R10 dead gap", g, DEAD);

    // small step: uc = 304 + 9*59 = 835 -> level 512
    repeat (60) send_gap(8000, -2000, 10);
    repeat (2100) @(negedge clk);
    count_on(1, 2000, c);
    chk("R3 R7 duty after step", c, 2 * 512 - DEAD);

    // drive to the positive rail
    repeat (700) send_gap(32767, -32768, 10);
    repeat (4100) @(negedge clk);
    chk("R4 sat at positive rail", int'(sat), 1);
    count_on(1, 2000, c);
    chk("R8 high side full period", c, 2000);

    // reversal leaves the rail at once
    send_gap(-10000, 10000, 2);
    chk("R5 sat cleared after reversal", int'(sat), 0);

    // drive to the negative rail
    repeat (1100) send_gap(-32768, 32767, 10);
    repeat (4100) @(negedge clk);
    chk("R4 sat at negative rail", int'(sat), 1);
    count_on(0, 2000, c);
    chk("R8 low side full period", c, 2000);

    // back-to-back samples exercise the ready rule
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      send(int'($signed(seed[25:10])), int'($signed(seed[30:15])));
    end
    for (int k = 0; k < 60; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      send_gap(int'($signed(seed[27:12])), int'($signed(seed[22:7])) / 2, 7);
    end
    repeat (2500) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule